// File: doc/BRIEF.md
# Time-Sliced Two-Input Frame Stream Merger

The block joins two frame streams into one output stream. Each stream carries wide data words split into regions. Every region has its own frame-start flag, frame-end flag, start and end position fields and a metadata field. All three ports use a valid/ready handshake. At any time one input owns the output. A slice counter measures how long it has owned it, counting only the cycles in which the output is ready. When the slice runs out, the block tries to hand the output to the other input. The hand-over happens only at a point that keeps every frame whole, so frames from the two sources never interleave.

When masking is enabled at compile time, a word can close one frame and open the next. Such a word can be split across a hand-over. The first copy goes out with the later start flags removed, and the source is not acknowledged. When the source owns the output again, the same word is sent a second time. This copy carries only the flags that belong after the split point, and it acknowledges the source. When masking is disabled, the block waits for a word that leaves no frame open.

Top module: `slice_merge2`

## Requirements
- R1: Reset is synchronous and active low. It selects input 0, clears the slice counter and clears the open-frame state of both inputs. In the first cycle after reset, `in0_ready` equals `out_ready`, `in1_ready` is 0, and the output carries input 0.
- R2: The data, metadata, start position and end position of the selected input reach the output unchanged. Its start and end flags also reach the output unchanged, except during a split transfer or a resend.
- R3: `out_valid` equals the selected input's valid. `out_ready` is passed only to the selected input, and the other input's ready is held at 0.
- R4: The slice counter advances only in cycles where `out_ready` is 1. After `SLICE_MAX` such cycles, the slice has expired, and every later cycle is a hand-over attempt until the counter restarts.
- R5: If the other input is not valid in an attempt cycle, the selection stays, the counter restarts from 0, and the next attempt comes only after another `SLICE_MAX` ready cycles.
- R6: In an attempt cycle with the other input valid, a transferred word of the current input that leaves no frame open is acknowledged in full, and the selection switches at that clock edge.
- R7: In an attempt cycle, if the current input is not valid, has no open frame and the other input is valid, the selection switches at that clock edge without any transfer.
- R8: While the current input has an open frame and its word cannot be split, the selection does not change. This holds even after the slice has expired.
- R9: With masking enabled, a word may arrive in an attempt cycle with the other input valid, where the word closes a frame and a later start leaves a frame open. The word is then sent with every start flag after the first close cleared, and every end flag after it cleared. `in*_ready` of the current input is 0, and the selection switches.
- R10: When the split input is selected again, the same word is resent. In the resent copy, the start and end flags up to the first close are cleared and the later flags are kept. This transfer acknowledges the input.
- R11: Flags in a word are read from region 0 upward, and region r uses bit r. If a region has both flags set while a frame is open, the end comes first and a new frame then opens in that region. If a region has both flags set while no frame is open, it holds a complete frame.
- R12: With masking disabled, no word is split. A word that leaves a frame open is always passed with its flags intact and acknowledged, and the selection stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in0_data | input | DATA_W | Input 0 data word |
| in0_meta | input | REGIONS*META_W | Input 0 metadata, one field per region |
| in0_sof | input | REGIONS | Input 0 frame-start flag per region |
| in0_sof_pos | input | SOFP_W | Input 0 start block index per region |
| in0_eof | input | REGIONS | Input 0 frame-end flag per region |
| in0_eof_pos | input | EOFP_W | Input 0 end item index per region |
| in0_valid | input | 1 | Input 0 word valid |
| in0_ready | output | 1 | Input 0 word accepted |
| in1_data | input | DATA_W | Input 1 data word |
| in1_meta | input | REGIONS*META_W | Input 1 metadata |
| in1_sof | input | REGIONS | Input 1 frame-start flags |
| in1_sof_pos | input | SOFP_W | Input 1 start positions |
| in1_eof | input | REGIONS | Input 1 frame-end flags |
| in1_eof_pos | input | EOFP_W | Input 1 end positions |
| in1_valid | input | 1 | Input 1 word valid |
| in1_ready | output | 1 | Input 1 word accepted |
| out_data | output | DATA_W | Merged data word |
| out_meta | output | REGIONS*META_W | Merged metadata |
| out_sof | output | REGIONS | Merged start flags |
| out_sof_pos | output | SOFP_W | Merged start positions |
| out_eof | output | REGIONS | Merged end flags |
| out_eof_pos | output | EOFP_W | Merged end positions |
| out_valid | output | 1 | Merged word valid |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Some properties hold in every cycle, and the assertions check them there. The output valid follows the owner. At most one input ever sees ready. The counter stays in range and moves only on ready cycles. Selection changes only after an expired slice, the input being left never has an open frame, and a split always ends in a hand-over. Other behaviour needs a known history, so only the directed scenarios can show it. These are the exact cycle of each hand-over, the restart after a failed attempt, the flag masks on the split copy and on the resend, the region ordering of doubled flags, and the contrast with masking disabled.

// File: rtl/slice_merge_pkg.sv
package slice_merge_pkg;

    // Width of an index field over n slots, at least one bit wide.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/slice_merge_scan.sv
// slice_merge_scan
// Walks the start/end flags of one word from region 0 upward. It starts
// from the frame-open state the input had before the word.
// It reports whether a frame is left open after the word, and whether
// the word has a close point (the first region where a frame ends).
// It also gives keep masks for the two copies of a split word: the copy
// sent before a hand-over, and the resend after it.
// Assumes a region with both flags set while open means end-then-start.
module slice_merge_scan #(
    parameter int unsigned REGIONS = 2
) (
    input  logic               open_in,
    input  logic [REGIONS-1:0] sof,
    input  logic [REGIONS-1:0] eof,
    output logic               open_out,
    output logic               has_close,
    output logic [REGIONS-1:0] first_sof_keep,
    output logic [REGIONS-1:0] first_eof_keep,
    output logic [REGIONS-1:0] rest_sof_keep,
    output logic [REGIONS-1:0] rest_eof_keep
);
    logic [REGIONS:0] open_chain;
    logic [REGIONS:0] seen_chain;

    assign open_chain[0] = open_in;
    assign seen_chain[0] = 1'b0;

    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        logic o_in;
        logic close_here;
        assign o_in = open_chain[r];
        // Purpose: a frame ends in this region (open end, or a complete frame).
        assign close_here    = o_in ? eof[r] : (sof[r] & eof[r]);
        assign open_chain[r+1] = o_in ? (eof[r] ? sof[r] : 1'b1)
                                      : (sof[r] & ~eof[r]);
        assign seen_chain[r+1] = seen_chain[r] | close_here;

        // Purpose: split masks; after the close point everything belongs to the resend.
        always_comb begin
            if (seen_chain[r]) begin
                first_sof_keep[r] = 1'b0;
                first_eof_keep[r] = 1'b0;
                rest_sof_keep[r]  = 1'b1;
                rest_eof_keep[r]  = 1'b1;
            end else if (close_here) begin
                first_sof_keep[r] = ~o_in;
                first_eof_keep[r] = 1'b1;
                rest_sof_keep[r]  = o_in;
                rest_eof_keep[r]  = 1'b0;
            end else begin
                first_sof_keep[r] = 1'b1;
                first_eof_keep[r] = 1'b1;
                rest_sof_keep[r]  = 1'b0;
                rest_eof_keep[r]  = 1'b0;
            end
        end
    end

    assign open_out  = open_chain[REGIONS];
    assign has_close = seen_chain[REGIONS];

endmodule

// File: rtl/slice_merge_ctrl.sv
// slice_merge_ctrl
// Owns the selection, the slice counter, the per-input open-frame bits and
// the per-input flag keep masks that mark a pending resend.
// It decides in each cycle whether to hand over, split or stay.
// Assumes a source holds a word stable until its ready is seen.
module slice_merge_ctrl #(
    parameter int unsigned REGIONS   = 2,
    parameter bit          MASK_EN   = 1'b1,
    parameter int unsigned SLICE_MAX = 64,
    localparam int unsigned CNT_W    = $clog2(SLICE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         rx_valid,
    input  logic               out_ready,
    input  logic               word_open,
    input  logic               word_close,
    input  logic [REGIONS-1:0] rest_sof_keep,
    input  logic [REGIONS-1:0] rest_eof_keep,
    output logic               sel_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [1:0]         open_q,
    output logic               cur_open,
    output logic [REGIONS-1:0] cur_sof_keep,
    output logic [REGIONS-1:0] cur_eof_keep,
    output logic               split_dec
);
    logic [REGIONS-1:0] keep_sof_q [2];
    logic [REGIONS-1:0] keep_eof_q [2];
    logic expired, oth_vld, cur_vld, idle_sw, word_sw, do_switch, ack, split_take;

    assign cur_open     = open_q[sel_q];
    assign cur_sof_keep = keep_sof_q[sel_q];
    assign cur_eof_keep = keep_eof_q[sel_q];

    // Purpose: classify the current cycle as stay, hand-over or split.
    always_comb begin
        expired    = (cnt_q == CNT_W'(SLICE_MAX));
        oth_vld    = rx_valid[~sel_q];
        cur_vld    = rx_valid[sel_q];
        split_dec  = MASK_EN && expired && oth_vld && cur_vld && word_open && word_close;
        idle_sw    = expired && oth_vld && !cur_vld && !open_q[sel_q];
        word_sw    = expired && oth_vld && cur_vld && out_ready && !word_open;
        split_take = split_dec && out_ready;
        do_switch  = idle_sw || word_sw || split_take;
        ack        = cur_vld && out_ready && !split_dec;
    end

    // Purpose: selection and slice counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            cnt_q <= '0;
        end else if (do_switch) begin
            sel_q <= ~sel_q;
            cnt_q <= '0;
        end else if (expired && !oth_vld) begin
            cnt_q <= '0;
        end else if (out_ready && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: per-input open-frame bit and pending-resend keep masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int i = 0; i < 2; i++) begin
                keep_sof_q[i] <= '1;
                keep_eof_q[i] <= '1;
            end
        end else if (ack) begin
            open_q[sel_q]     <= word_open;
            keep_sof_q[sel_q] <= '1;
            keep_eof_q[sel_q] <= '1;
        end else if (split_take) begin
            open_q[sel_q]     <= 1'b0;
            keep_sof_q[sel_q] <= keep_sof_q[sel_q] & rest_sof_keep;
            keep_eof_q[sel_q] <= keep_eof_q[sel_q] & rest_eof_keep;
        end
    end

endmodule

// File: rtl/slice_merge2.sv
// slice_merge2
// Merges two multi-region frame streams into one by counted time slices.
// The data path is a plain multiplexer. Only the flags are masked, and
// only on split and resend words. Control lives in slice_merge_ctrl and the
// per-word frame walk lives in slice_merge_scan.
// Assumes both sources obey the valid/ready rule and keep a word steady until accepted.
module slice_merge2
    import slice_merge_pkg::*;
#(
    parameter int unsigned REGIONS   = 2,
    parameter int unsigned BLOCKS    = 8,
    parameter int unsigned ITEMS     = 8,
    parameter int unsigned ITEM_W    = 8,
    parameter int unsigned META_W    = 8,
    parameter bit          MASK_EN   = 1'b1,
    parameter int unsigned SLICE_MAX = 64,
    localparam int unsigned DATA_W   = REGIONS * BLOCKS * ITEMS * ITEM_W,
    localparam int unsigned MTA_W    = REGIONS * META_W,
    localparam int unsigned SOFP_W   = REGIONS * idx_w(BLOCKS),
    localparam int unsigned EOFP_W   = REGIONS * idx_w(BLOCKS * ITEMS),
    localparam int unsigned CNT_W    = $clog2(SLICE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  in0_data,
    input  logic [MTA_W-1:0]   in0_meta,
    input  logic [REGIONS-1:0] in0_sof,
    input  logic [SOFP_W-1:0]  in0_sof_pos,
    input  logic [REGIONS-1:0] in0_eof,
    input  logic [EOFP_W-1:0]  in0_eof_pos,
    input  logic               in0_valid,
    output logic               in0_ready,
    input  logic [DATA_W-1:0]  in1_data,
    input  logic [MTA_W-1:0]   in1_meta,
    input  logic [REGIONS-1:0] in1_sof,
    input  logic [SOFP_W-1:0]  in1_sof_pos,
    input  logic [REGIONS-1:0] in1_eof,
    input  logic [EOFP_W-1:0]  in1_eof_pos,
    input  logic               in1_valid,
    output logic               in1_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic [MTA_W-1:0]   out_meta,
    output logic [REGIONS-1:0] out_sof,
    output logic [SOFP_W-1:0]  out_sof_pos,
    output logic [REGIONS-1:0] out_eof,
    output logic [EOFP_W-1:0]  out_eof_pos,
    output logic               out_valid,
    input  logic               out_ready
);
    logic               sel_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         open_q;
    logic               cur_open, split_dec, word_open, word_close;
    logic [REGIONS-1:0] cur_sof_keep, cur_eof_keep;
    logic [REGIONS-1:0] eff_sof, eff_eof;
    logic [REGIONS-1:0] first_sof_keep, first_eof_keep, rest_sof_keep, rest_eof_keep;

    // Purpose: pass the selected input's payload through untouched.
    always_comb begin
        out_data    = sel_q ? in1_data    : in0_data;
        out_meta    = sel_q ? in1_meta    : in0_meta;
        out_sof_pos = sel_q ? in1_sof_pos : in0_sof_pos;
        out_eof_pos = sel_q ? in1_eof_pos : in0_eof_pos;
        out_valid   = sel_q ? in1_valid   : in0_valid;
        eff_sof     = (sel_q ? in1_sof : in0_sof) & cur_sof_keep;
        eff_eof     = (sel_q ? in1_eof : in0_eof) & cur_eof_keep;
    end

    assign in0_ready = out_ready && !sel_q && !split_dec;
    assign in1_ready = out_ready &&  sel_q && !split_dec;

    // Purpose: the flag masking stage exists only when splitting is enabled.
    if (MASK_EN) begin : g_mask
        assign out_sof = split_dec ? (eff_sof & first_sof_keep) : eff_sof;
        assign out_eof = split_dec ? (eff_eof & first_eof_keep) : eff_eof;
    end else begin : g_nomask
        assign out_sof = eff_sof;
        assign out_eof = eff_eof;
    end

    slice_merge_scan #(.REGIONS(REGIONS)) u_scan (
        .open_in        (cur_open),
        .sof            (eff_sof),
        .eof            (eff_eof),
        .open_out       (word_open),
        .has_close      (word_close),
        .first_sof_keep (first_sof_keep),
        .first_eof_keep (first_eof_keep),
        .rest_sof_keep  (rest_sof_keep),
        .rest_eof_keep  (rest_eof_keep)
    );

    slice_merge_ctrl #(
        .REGIONS   (REGIONS),
        .MASK_EN   (MASK_EN),
        .SLICE_MAX (SLICE_MAX)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      ({in1_valid, in0_valid}),
        .out_ready     (out_ready),
        .word_open     (word_open),
        .word_close    (word_close),
        .rest_sof_keep (rest_sof_keep),
        .rest_eof_keep (rest_eof_keep),
        .sel_q         (sel_q),
        .cnt_q         (cnt_q),
        .open_q        (open_q),
        .cur_open      (cur_open),
        .cur_sof_keep  (cur_sof_keep),
        .cur_eof_keep  (cur_eof_keep),
        .split_dec     (split_dec)
    );

endmodule

// File: rtl/slice_merge2_chk.sv
// slice_merge2_chk
// Cycle-level properties of slice_merge2. It is bound to every instance
// of it and only observes ports and control state.
module slice_merge2_chk #(
    parameter int unsigned SLICE_MAX = 64,
    parameter int unsigned CNT_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       open_q,
    input logic             split_dec,
    input logic             in0_valid,
    input logic             in1_valid,
    input logic             in0_ready,
    input logic             in1_ready,
    input logic             out_valid,
    input logic             out_ready
);
    logic left_open;
    assign left_open = sel_q ? open_q[0] : open_q[1];

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_q == 1'b0 && cnt_q == '0 && open_q == 2'b00));

    a_r3_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(in0_ready && in1_ready));

    a_r3_valid_owner: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (sel_q ? in1_valid : in0_valid));

    a_r3_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q ? in0_ready : in1_ready) == 1'b0);

    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLICE_MAX));

    a_r4_cnt_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(out_ready));

    a_r6_switch_after_slice: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> ($past(cnt_q) == CNT_W'(SLICE_MAX)));

    a_r8_left_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> !left_open);

    a_r9_split_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        (split_dec && out_ready) |=> (sel_q != $past(sel_q)));

endmodule

bind slice_merge2 slice_merge2_chk #(
    .SLICE_MAX (SLICE_MAX),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_q     (sel_q),
    .cnt_q     (cnt_q),
    .open_q    (open_q),
    .split_dec (split_dec),
    .in0_valid (in0_valid),
    .in1_valid (in1_valid),
    .in0_ready (in0_ready),
    .in1_ready (in1_ready),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/tb_slice_merge2.sv
module tb_slice_merge2;
    localparam int DW = 64, MW = 8, SPW = 2, EPW = 4, RG = 2;

    logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] d0 = '0, d1 = '0;
    logic [RG-1:0] s0 = '0, e0 = '0, s1 = '0, e1 = '0;
    logic v0 = 1'b0, v1 = 1'b0;

    logic [DW-1:0] m_data, n_data;
    logic [MW-1:0] m_meta, n_meta;
    logic [RG-1:0] m_sof, m_eof, n_sof, n_eof;
    logic [SPW-1:0] m_sp, n_sp;
    logic [EPW-1:0] m_ep, n_ep;
    logic m_valid, n_valid, m_r0, m_r1, n_r0, n_r1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    localparam logic [DW-1:0] A = 64'h0A0A_0000_0000_0100;
    localparam logic [DW-1:0] B = 64'h0B0B_0000_0000_0200;
    localparam logic [DW-1:0] W = 64'h0C0C_0000_0000_0300;

    always #5 clk = ~clk;

    slice_merge2 #(.REGIONS(2), .BLOCKS(2), .ITEMS(2), .ITEM_W(8), .META_W(4),
                   .MASK_EN(1'b1), .SLICE_MAX(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .in0_data(d0), .in0_meta(d0[7:0]), .in0_sof(s0), .in0_sof_pos(d0[9:8]),
        .in0_eof(e0), .in0_eof_pos(d0[15:12]), .in0_valid(v0), .in0_ready(m_r0),
        .in1_data(d1), .in1_meta(d1[7:0]), .in1_sof(s1), .in1_sof_pos(d1[9:8]),
        .in1_eof(e1), .in1_eof_pos(d1[15:12]), .in1_valid(v1), .in1_ready(m_r1),
        .out_data(m_data), .out_meta(m_meta), .out_sof(m_sof), .out_sof_pos(m_sp),
        .out_eof(m_eof), .out_eof_pos(m_ep), .out_valid(m_valid), .out_ready(out_ready));

    slice_merge2 #(.REGIONS(2), .BLOCKS(2), .ITEMS(2), .ITEM_W(8), .META_W(4),
                   .MASK_EN(1'b0), .SLICE_MAX(4)) dut_nomask (
        .clk(clk), .rst_n(rst_n),
        .in0_data(d0), .in0_meta(d0[7:0]), .in0_sof(s0), .in0_sof_pos(d0[9:8]),
        .in0_eof(e0), .in0_eof_pos(d0[15:12]), .in0_valid(v0), .in0_ready(n_r0),
        .in1_data(d1), .in1_meta(d1[7:0]), .in1_sof(s1), .in1_sof_pos(d1[9:8]),
        .in1_eof(e1), .in1_eof_pos(d1[15:12]), .in1_valid(v1), .in1_ready(n_r1),
        .out_data(n_data), .out_meta(n_meta), .out_sof(n_sof), .out_sof_pos(n_sp),
        .out_eof(n_eof), .out_eof_pos(n_ep), .out_valid(n_valid), .out_ready(out_ready));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive0(input logic v, input logic [1:0] s, input logic [1:0] e, input logic [DW-1:0] d);
        v0 = v; s0 = s; e0 = e; d0 = d;
    endtask

    task automatic drive1(input logic v, input logic [1:0] s, input logic [1:0] e, input logic [DW-1:0] d);
        v1 = v; s1 = s; e1 = e; d1 = d;
    endtask

    // Resets both instances; returns at the negedge that begins cycle 1.
    task automatic do_reset();
        rst_n = 1'b0; out_ready = 1'b0;
        drive0(1'b0, 2'b00, 2'b00, '0);
        drive1(1'b0, 2'b00, 2'b00, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        drive0(1'b1, 2'b01, 2'b01, A);
        drive1(1'b1, 2'b01, 2'b01, B);
        out_ready = 1'b1;
        #1;
        chk("R1 out_data from input 0", m_data, A);
        chk("R1 in0_ready", m_r0, 1);
        chk("R1 in1_ready", m_r1, 0);
        @(negedge clk);
    endtask

    task automatic t_pass();
        logic [DW-1:0] p;
        p = 64'h1234_5678_9ABC_7E5D;
        do_reset();
        drive0(1'b1, 2'b01, 2'b01, p);
        out_ready = 1'b1;
        #1;
        chk("R2 data", m_data, p);
        chk("R2 meta", m_meta, p[7:0]);
        chk("R2 sof_pos", m_sp, p[9:8]);
        chk("R2 eof_pos", m_ep, p[15:12]);
        chk("R2 sof", m_sof, 2'b01);
        chk("R2 eof", m_eof, 2'b01);
        chk("R3 out_valid", m_valid, 1);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk("R3 ready follows out_ready", m_r0, 0);
        @(negedge clk);
        drive0(1'b0, 2'b01, 2'b01, p);
        #1;
        chk("R3 valid follows input", m_valid, 0);
        @(negedge clk);
    endtask

    task automatic t_count();
        do_reset();
        drive0(1'b1, 2'b01, 2'b01, A);
        drive1(1'b1, 2'b01, 2'b01, B);
        repeat (10) @(negedge clk);
        #1;
        chk("R4 no switch without ready", m_data, A);
        out_ready = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            #1;
            if (c == 4) chk("R4 still input 0 before expiry", m_data, A);
            if (c == 5) begin
                chk("R6 closed word acknowledged", m_r0, 1);
                chk("R11 single-region frame is closed", m_data, A);
            end
            if (c == 6) begin
                chk("R6 switched to input 1", m_data, B);
                chk("R6 in1_ready", m_r1, 1);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_retry();
        do_reset();
        drive0(1'b1, 2'b01, 2'b01, A);
        out_ready = 1'b1;
        for (int c = 1; c <= 11; c++) begin
            if (c == 6) drive1(1'b1, 2'b01, 2'b01, B);
            #1;
            if (c == 5) chk("R5 stays when other idle", m_data, A);
            if (c == 9) chk("R5 waits a full new slice", m_data, A);
            if (c == 11) chk("R5 switch after new slice", m_data, B);
            @(negedge clk);
        end
    endtask

    task automatic t_idle();
        do_reset();
        drive1(1'b1, 2'b01, 2'b01, B);
        out_ready = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            #1;
            if (c == 1) chk("R7 in1 not ready before switch", m_r1, 0);
            if (c == 5) chk("R7 no output while input 0 idle", m_valid, 0);
            if (c == 6) begin
                chk("R7 switched to input 1", m_data, B);
                chk("R7 in1_ready after switch", m_r1, 1);
                chk("R7 in0_ready after switch", m_r0, 0);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_open();
        do_reset();
        drive1(1'b1, 2'b01, 2'b01, B);
        out_ready = 1'b1;
        for (int c = 1; c <= 8; c++) begin
            if (c == 1)      drive0(1'b1, 2'b01, 2'b00, A + DW'(c));
            else if (c == 7) drive0(1'b1, 2'b00, 2'b10, A + DW'(c));
            else             drive0(1'b1, 2'b00, 2'b00, A + DW'(c));
            #1;
            if (c == 6) begin
                chk("R8 stays inside open frame", m_data, A + 6);
                chk("R8 other input held off", m_r1, 0);
                chk("R8 no-mask stays inside open frame", n_data, A + 6);
            end
            if (c == 7) chk("R6 closing word acknowledged", m_r0, 1);
            if (c == 8) begin
                chk("R6 switch after frame end", m_data, B);
                chk("R6 no-mask switch after frame end", n_data, B);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_split(input logic [1:0] ws, input logic [1:0] we,
                           input logic [1:0] p1s, input logic [1:0] p2s, input logic [1:0] p2e,
                           input string tag);
        do_reset();
        drive1(1'b1, 2'b01, 2'b01, B);
        out_ready = 1'b1;
        for (int c = 1; c <= 12; c++) begin
            if (c == 1)       drive0(1'b1, 2'b01, 2'b00, A + DW'(c));
            else if (c <= 4)  drive0(1'b1, 2'b00, 2'b00, A + DW'(c));
            else if (c <= 11) drive0(1'b1, ws, we, W);
            else              drive0(1'b1, 2'b00, 2'b10, W + 1);
            #1;
            if (c == 5) begin
                chk({"R9 first copy sof ", tag}, m_sof, p1s);
                chk({"R9 first copy eof ", tag}, m_eof, we);
                chk({"R9 first copy not acknowledged ", tag}, m_r0, 0);
                chk({"R9 first copy data ", tag}, m_data, W);
                chk({"R12 no-mask flags intact sof ", tag}, n_sof, ws);
                chk({"R12 no-mask acknowledged ", tag}, n_r0, 1);
            end
            if (c == 6) begin
                chk({"R9 handed over ", tag}, m_data, B);
                chk({"R12 no-mask stays ", tag}, n_data, W);
            end
            if (c == 10) chk({"R10 other slice still running ", tag}, m_data, B);
            if (c == 11) begin
                chk({"R10 resend data ", tag}, m_data, W);
                chk({"R10 resend sof ", tag}, m_sof, p2s);
                chk({"R10 resend eof ", tag}, m_eof, p2e);
                chk({"R10 resend acknowledged ", tag}, m_r0, 1);
            end
            if (c == 12) chk({"R10 next word follows resend ", tag}, m_data, W + 1);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_pass();
        t_count();
        t_retry();
        t_idle();
        t_open();
        // End in region 0, start in region 1.
        t_split(2'b10, 2'b01, 2'b00, 2'b10, 2'b00, "end r0 start r1");
        // R11: region 0 carries end then start while a frame is open.
        t_split(2'b01, 2'b01, 2'b00, 2'b01, 2'b00, "R11 end-then-start in r0");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule